// File: doc/BRIEF.md
# Dual-Master RAM Write Protection Unit

This block sits beside a RAM shared by a main CPU and a coprocessor and judges every write request from each of them in the same cycle it is presented. Software defines two address windows through a small register bus: a window private to the coprocessor and a window both masters may use. Each window is set by an inclusive lower and upper bound. A control register switches protection on, enables an interrupt, and holds a sticky violation flag.

With protection off, every write goes through. With protection on, the CPU may not write into the coprocessor window, and the coprocessor may write only inside its own window or the shared one. A blocked CPU write sets the violation flag, which raises the interrupt line when the interrupt is enabled. While protection is on, the window bounds are frozen, so a running program cannot widen its own permissions. Write permission is a combinational function of the request address and the registered state. Register writes take effect at the next clock edge.

Top module: `ram_wprot_unit`

## Requirements
- R1: With the protect bit (control bit 0) at 0, `cpu_wr_ok` equals `cpu_wr_vld` and `cop_wr_ok` equals `cop_wr_vld`, for any address.
- R2: With protect at 1, a CPU write whose address lies in the coprocessor window gives `cpu_wr_ok` = 0. A CPU write outside that window gives `cpu_wr_ok` = 1.
- R3: With protect at 1, `cop_wr_ok` is 1 only when the coprocessor address lies in the coprocessor window or in the shared window.
- R4: Register selects 1 to 4 (coprocessor low, coprocessor high, shared low, shared high) accept writes only while protect is 0. While protect is 1, writes to them leave the read-back value unchanged.
- R5: A CPU write blocked under R2 sets the violation flag (control bit 2) at the next clock edge. The flag stays set until software clears it. Blocked coprocessor writes leave the flag alone.
- R6: A control write with bit 2 at 1 clears the flag. A control write with bit 2 at 0 leaves the flag unchanged. Bits 0 and 1 of a control write load protect and interrupt-enable.
- R7: `irq` is 1 exactly when interrupt-enable (control bit 1) and the flag are both 1.
- R8: Reading select 0 returns protect, interrupt-enable and flag in bits 0, 1 and 2, and 0 in every other bit. Selects 5 to 7 read as 0.
- R9: Window membership includes both bounds. Addresses are compared at word granularity, so the low address bits below the word size are ignored on the address and on the bounds.
- R10: If a flag-setting CPU write and a flag-clearing control write fall in the same cycle, the flag ends up set.
- R11: After reset, the control bits and the flag are 0. Every low bound reads all ones and every high bound reads 0, which makes both windows empty.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cpu_wr_vld | input | 1 | CPU write request |
| cpu_wr_addr | input | ADDR_W | CPU write byte address |
| cpu_wr_ok | output | 1 | CPU write permitted |
| cop_wr_vld | input | 1 | Coprocessor write request |
| cop_wr_addr | input | ADDR_W | Coprocessor write byte address |
| cop_wr_ok | output | 1 | Coprocessor write permitted |
| reg_wr | input | 1 | Register write strobe |
| reg_sel | input | 3 | Register select (0 control, 1..4 bounds) |
| reg_wdata | input | ADDR_W | Register write data |
| reg_rdata | output | ADDR_W | Register read data for `reg_sel` |
| irq | output | 1 | Violation interrupt |

## Verification
Two events can reach the violation flag in the same cycle: the hardware set from a blocked CPU write, and the software clear from a control write with bit 2 at 1. The bench provokes this by holding a CPU request inside the coprocessor window while it issues the clearing control write on the same clock edge. It then judges the result by reading the flag back through select 0, where it must still be 1. A later clear with no CPU request present must leave the flag at 0.

// File: rtl/ram_wprot_pkg.sv
package ram_wprot_pkg;

    typedef enum logic [2:0] {
        SEL_CTRL   = 3'd0,
        SEL_COP_LO = 3'd1,
        SEL_COP_HI = 3'd2,
        SEL_SHR_LO = 3'd3,
        SEL_SHR_HI = 3'd4
    } reg_sel_e;

    localparam int CTL_PROT = 0;
    localparam int CTL_IE   = 1;
    localparam int CTL_FLAG = 2;

    localparam int NUM_WIN  = 2;   // window 0 = coprocessor, 1 = shared

endpackage

// File: rtl/wprot_region_chk.sv
module wprot_region_chk #(
    parameter int ADDR_W = 16,
    parameter int OFS_W  = 1
) (
    input  logic [ADDR_W-1:0] addr,
    input  logic [ADDR_W-1:0] lo,
    input  logic [ADDR_W-1:0] hi,
    output logic              hit
);
    localparam logic [ADDR_W-1:0] WORD_MASK = ~((ADDR_W)'((1 << OFS_W) - 1));

    logic [ADDR_W-1:0] a_w, lo_w, hi_w;

    always_comb begin
        a_w  = addr & WORD_MASK;
        lo_w = lo   & WORD_MASK;
        hi_w = hi   & WORD_MASK;
        hit  = (a_w >= lo_w) && (a_w <= hi_w);
    end

endmodule

// File: rtl/wprot_regs.sv
module wprot_regs
    import ram_wprot_pkg::*;
#(
    parameter int ADDR_W = 16
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic                         reg_wr,
    input  logic [2:0]                   reg_sel,
    input  logic [ADDR_W-1:0]            reg_wdata,
    output logic [ADDR_W-1:0]            reg_rdata,
    input  logic                         viol_set,
    output logic                         prot_en,
    output logic                         irq_en,
    output logic                         flag,
    output logic [2*NUM_WIN-1:0][ADDR_W-1:0] bounds
);
    localparam int NB = 2 * NUM_WIN;

    typedef struct packed {
        logic                  prot;
        logic                  ie;
        logic                  flag;
        logic [NB-1:0][ADDR_W-1:0] bnd;   // index = select - 1
    } state_t;

    state_t st_d, st_q;
    reg_sel_e sel;

    always_comb begin
        sel  = reg_sel_e'(reg_sel);
        st_d = st_q;
        if (reg_wr) begin
            if (sel == SEL_CTRL) begin
                st_d.prot = reg_wdata[CTL_PROT];
                st_d.ie   = reg_wdata[CTL_IE];
                if (reg_wdata[CTL_FLAG]) st_d.flag = 1'b0;
            end else if (!st_q.prot && reg_sel >= 3'd1 && reg_sel <= 3'(NB)) begin
                st_d.bnd[reg_sel - 3'd1] = reg_wdata;
            end
        end
        if (viol_set) st_d.flag = 1'b1;          // set beats clear

        reg_rdata = '0;
        if (sel == SEL_CTRL) begin
            reg_rdata[CTL_PROT] = st_q.prot;
            reg_rdata[CTL_IE]   = st_q.ie;
            reg_rdata[CTL_FLAG] = st_q.flag;
        end else if (reg_sel >= 3'd1 && reg_sel <= 3'(NB)) begin
            reg_rdata = st_q.bnd[reg_sel - 3'd1];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q.prot <= 1'b0;
            st_q.ie   <= 1'b0;
            st_q.flag <= 1'b0;
            for (int i = 0; i < NB; i++)
                st_q.bnd[i] <= (i % 2 == 0) ? '1 : '0;   // low = ones, high = zero
        end else begin
            st_q <= st_d;
        end
    end

    assign prot_en = st_q.prot;
    assign irq_en  = st_q.ie;
    assign flag    = st_q.flag;
    assign bounds  = st_q.bnd;

    a_r4_bound_lock: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_wr && st_q.prot && reg_sel != 3'd0) |=> $stable(st_q.bnd));

    a_r10_set_wins: assert property (@(posedge clk) disable iff (!rst_n)
        viol_set |=> st_q.flag);

    a_r6_w1c: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_wr && reg_sel == 3'd0 && reg_wdata[CTL_FLAG] && !viol_set) |=> !st_q.flag);

endmodule

// File: rtl/ram_wprot_unit.sv
module ram_wprot_unit
    import ram_wprot_pkg::*;
#(
    parameter int ADDR_W     = 16,
    parameter int WORD_BYTES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cpu_wr_vld,
    input  logic [ADDR_W-1:0] cpu_wr_addr,
    output logic              cpu_wr_ok,
    input  logic              cop_wr_vld,
    input  logic [ADDR_W-1:0] cop_wr_addr,
    output logic              cop_wr_ok,
    input  logic              reg_wr,
    input  logic [2:0]        reg_sel,
    input  logic [ADDR_W-1:0] reg_wdata,
    output logic [ADDR_W-1:0] reg_rdata,
    output logic              irq
);
    localparam int OFS_W = (WORD_BYTES > 1) ? $clog2(WORD_BYTES) : 0;

    logic prot_en, irq_en, flag, viol_set;
    logic [2*NUM_WIN-1:0][ADDR_W-1:0] bounds;
    logic [NUM_WIN-1:0] cop_hit;
    logic cpu_in_cop;

    wprot_regs #(.ADDR_W(ADDR_W)) u_regs (
        .clk       (clk),
        .rst_n     (rst_n),
        .reg_wr    (reg_wr),
        .reg_sel   (reg_sel),
        .reg_wdata (reg_wdata),
        .reg_rdata (reg_rdata),
        .viol_set  (viol_set),
        .prot_en   (prot_en),
        .irq_en    (irq_en),
        .flag      (flag),
        .bounds    (bounds)
    );

    wprot_region_chk #(.ADDR_W(ADDR_W), .OFS_W(OFS_W)) u_cpu_chk (
        .addr (cpu_wr_addr),
        .lo   (bounds[0]),
        .hi   (bounds[1]),
        .hit  (cpu_in_cop)
    );

    for (genvar w = 0; w < NUM_WIN; w++) begin : g_cop_win
        wprot_region_chk #(.ADDR_W(ADDR_W), .OFS_W(OFS_W)) u_chk (
            .addr (cop_wr_addr),
            .lo   (bounds[2*w]),
            .hi   (bounds[2*w+1]),
            .hit  (cop_hit[w])
        );
    end

    always_comb begin
        cpu_wr_ok = cpu_wr_vld && !(prot_en && cpu_in_cop);
        cop_wr_ok = cop_wr_vld && (!prot_en || (|cop_hit));
        viol_set  = cpu_wr_vld && prot_en && cpu_in_cop;
        irq       = irq_en && flag;
    end

    a_r1_open: assert property (@(posedge clk) disable iff (!rst_n)
        !prot_en |-> (cpu_wr_ok == cpu_wr_vld) && (cop_wr_ok == cop_wr_vld));

    a_r2_cpu_block: assert property (@(posedge clk) disable iff (!rst_n)
        (prot_en && cpu_in_cop) |-> !cpu_wr_ok);

    a_r3_cop_confine: assert property (@(posedge clk) disable iff (!rst_n)
        (prot_en && cop_hit == '0) |-> !cop_wr_ok);

    a_r5_flag_record: assert property (@(posedge clk) disable iff (!rst_n)
        (cpu_wr_vld && !cpu_wr_ok) |=> flag);

endmodule

// File: tb/ram_wprot_unit_bench.sv
module ram_wprot_unit_bench;
    localparam int AW = 16;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic cpu_wr_vld = 1'b0, cop_wr_vld = 1'b0, reg_wr = 1'b0;
    logic [AW-1:0] cpu_wr_addr = '0, cop_wr_addr = '0, reg_wdata = '0;
    logic [2:0] reg_sel = '0;
    logic cpu_wr_ok, cop_wr_ok, irq;
    logic [AW-1:0] reg_rdata;

    int n_chk = 0, n_fail = 0;

    always #5 clk = ~clk;

    ram_wprot_unit #(.ADDR_W(AW), .WORD_BYTES(2)) u_ram_wprot_unit (
        .clk(clk), .rst_n(rst_n),
        .cpu_wr_vld(cpu_wr_vld), .cpu_wr_addr(cpu_wr_addr), .cpu_wr_ok(cpu_wr_ok),
        .cop_wr_vld(cop_wr_vld), .cop_wr_addr(cop_wr_addr), .cop_wr_ok(cop_wr_ok),
        .reg_wr(reg_wr), .reg_sel(reg_sel), .reg_wdata(reg_wdata),
        .reg_rdata(reg_rdata), .irq(irq)
    );

    task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic wr_reg(logic [2:0] s, logic [AW-1:0] d);
        @(negedge clk);
        reg_wr = 1'b1; reg_sel = s; reg_wdata = d;
        @(posedge clk);
        @(negedge clk);
        reg_wr = 1'b0;
    endtask

    task automatic rd_reg(logic [2:0] s, output logic [AW-1:0] d);
        @(negedge clk);
        reg_sel = s;
        #1 d = reg_rdata;
    endtask

    task automatic try_cpu(logic [AW-1:0] a, output logic ok);
        @(negedge clk);
        cpu_wr_vld = 1'b1; cpu_wr_addr = a;
        #1 ok = cpu_wr_ok;
        @(posedge clk);
        @(negedge clk);
        cpu_wr_vld = 1'b0;
    endtask

    task automatic try_cop(logic [AW-1:0] a, output logic ok);
        @(negedge clk);
        cop_wr_vld = 1'b1; cop_wr_addr = a;
        #1 ok = cop_wr_ok;
        @(posedge clk);
        @(negedge clk);
        cop_wr_vld = 1'b0;
    endtask

    function automatic logic [31:0] flag_of(logic [AW-1:0] c);
        return {31'd0, c[2]};
    endfunction

    task automatic t_reset();
        logic [AW-1:0] d;
        rd_reg(3'd0, d); chk("R11 ctrl", d, 0);
        rd_reg(3'd1, d); chk("R11 cop lo", d, 16'hFFFF);
        rd_reg(3'd2, d); chk("R11 cop hi", d, 0);
        rd_reg(3'd4, d); chk("R11 shr hi", d, 0);
        chk("R11 irq", irq, 0);
    endtask

    task automatic t_empty_windows();
        logic ok;
        wr_reg(3'd0, 16'h0001);
        try_cpu(16'h1234, ok); chk("R11 empty cop window cpu ok", ok, 1);
        try_cop(16'h1234, ok); chk("R11 empty windows cop blocked", ok, 0);
        wr_reg(3'd0, 16'h0000);
    endtask

    task automatic t_program();
        logic [AW-1:0] d;
        wr_reg(3'd1, 16'h1000); wr_reg(3'd2, 16'h10FE);
        wr_reg(3'd3, 16'h2000); wr_reg(3'd4, 16'h20FE);
        rd_reg(3'd3, d); chk("R4 unlocked write", d, 16'h2000);
        rd_reg(3'd6, d); chk("R8 unused select", d, 0);
    endtask

    task automatic t_open();
        logic ok;
        try_cpu(16'h1010, ok); chk("R1 cpu in cop window", ok, 1);
        try_cop(16'h5000, ok); chk("R1 cop anywhere", ok, 1);
        @(negedge clk); #1 chk("R1 no request", cpu_wr_ok, 0);
    endtask

    task automatic t_cpu_block();
        logic ok; logic [AW-1:0] d;
        wr_reg(3'd0, 16'h0001);
        try_cop(16'h5000, ok); chk("R3 cop outside", ok, 0);
        rd_reg(3'd0, d); chk("R5 cop violation no flag", flag_of(d), 0);
        try_cpu(16'h3000, ok); chk("R2 cpu outside", ok, 1);
        try_cpu(16'h1010, ok); chk("R2 cpu inside", ok, 0);
        rd_reg(3'd0, d); chk("R5 flag set", flag_of(d), 1);
        repeat (3) @(negedge clk);
        rd_reg(3'd0, d); chk("R5 flag sticky", flag_of(d), 1);
    endtask

    task automatic t_bounds();
        logic ok;
        try_cpu(16'h1000, ok); chk("R9 low bound", ok, 0);
        try_cpu(16'h10FE, ok); chk("R9 high bound", ok, 0);
        try_cpu(16'h10FF, ok); chk("R9 word align high", ok, 0);
        try_cpu(16'h0FFF, ok); chk("R9 below", ok, 1);
        try_cpu(16'h1100, ok); chk("R9 above", ok, 1);
        try_cop(16'h20FF, ok); chk("R9 shr high align", ok, 1);
        try_cop(16'h2100, ok); chk("R9 shr above", ok, 0);
        try_cop(16'h1FFE, ok); chk("R9 shr below", ok, 0);
    endtask

    task automatic t_cop();
        logic ok;
        try_cop(16'h1050, ok); chk("R3 own window", ok, 1);
        try_cop(16'h2050, ok); chk("R3 shared window", ok, 1);
        try_cop(16'h3000, ok); chk("R3 elsewhere", ok, 0);
    endtask

    task automatic t_irq();
        logic [AW-1:0] d;
        @(negedge clk); #1 chk("R7 ie off", irq, 0);
        wr_reg(3'd0, 16'h0003);
        #1 chk("R7 ie on flag on", irq, 1);
        rd_reg(3'd0, d); chk("R6 write 0 keeps flag", flag_of(d), 1);
        wr_reg(3'd0, 16'h0007);
        rd_reg(3'd0, d); chk("R6 write 1 clears", flag_of(d), 0);
        #1 chk("R7 flag off", irq, 0);
    endtask

    task automatic t_lock();
        logic [AW-1:0] d;
        wr_reg(3'd1, 16'h4000);
        rd_reg(3'd1, d); chk("R4 locked", d, 16'h1000);
        wr_reg(3'd0, 16'h0000);
        wr_reg(3'd1, 16'h0800);
        rd_reg(3'd1, d); chk("R4 unlocked", d, 16'h0800);
        wr_reg(3'd1, 16'h1000);
    endtask

    task automatic t_ctrl();
        logic [AW-1:0] d;
        wr_reg(3'd0, 16'hFFFF);
        rd_reg(3'd0, d); chk("R8 ctrl reserved zero", d, 16'h0003);
    endtask

    task automatic t_race();
        logic [AW-1:0] d;
        @(negedge clk);
        cpu_wr_vld = 1'b1; cpu_wr_addr = 16'h1020;
        reg_wr = 1'b1; reg_sel = 3'd0; reg_wdata = 16'h0007;
        @(posedge clk);
        @(negedge clk);
        cpu_wr_vld = 1'b0; reg_wr = 1'b0;
        rd_reg(3'd0, d); chk("R10 set beats clear", flag_of(d), 1);
        wr_reg(3'd0, 16'h0007);
        rd_reg(3'd0, d); chk("R10 later clear", flag_of(d), 0);
    endtask

    initial begin : watchdog
        repeat (20000) @(posedge clk);
        n_chk++; n_fail++;
        $display("FAIL watchdog expired actual=hung expected=done");
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        t_reset();
        t_empty_windows();
        t_program();
        t_open();
        t_cpu_block();
        t_bounds();
        t_cop();
        t_irq();
        t_lock();
        t_ctrl();
        t_race();
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end
endmodule